// File: doc/BRIEF.md
# Instruction Trace Exception Controller

This block sits beside a processor's execution pipeline and decides, once each instruction ends, whether a debug trace exception must follow it. The decision uses a two-bit trace mode field taken from the status register at the moment the instruction starts. There are two active modes. Single-step traps after every instruction that actually executes. Change-of-flow traps only when the instruction moved the program counter out of sequential order, such as a taken branch, jump, call, return or status register write. An instruction that never executes produces no trap: this covers an instruction displaced by an interrupt and one rejected as illegal, unimplemented or privileged.

When a trap is raised, the controller captures the exception frame: the address of the traced instruction, a format and vector-offset word, the next program counter and a copy of the status register. It then holds the pipeline stalled while it hands those words, one per cycle, to a stack writer over a valid/ready handshake. Instruction-end events that arrive while a frame is still pending are ignored, so the exception sequence itself is never traced. The reserved mode encoding behaves as tracing off, and a sticky flag records that it was seen.

Top module: `instr_trace_ctl`

## Requirements
- R1: After reset, trace_req_o, stall_o, push_valid_o, push_done_o and rsvd_mode_o are all low.
- R2: The mode is taken from trace_mode_i in the cycle where instr_start_i is high. Later changes to trace_mode_i before instr_end_i do not alter that instruction's decision.
- R3: With mode 2'b00, no trace is raised.
- R4: With mode 2'b01, an executed instruction raises a trace only if flow_break_i is high at its end. A not-taken branch (flow_break_i low) raises none.
- R5: With mode 2'b10, every executed instruction raises a trace.
- R6: An instruction counts as executed only if retired_i is high and irq_taken_i and bad_opcode_i are both low. Otherwise no trace is raised in any mode.
- R7: A raised trace appears as a one-cycle trace_req_o pulse in the cycle after instr_end_i. stall_o rises in that same cycle and stays high until the frame has been pushed.
- R8: The frame is pushed as six 16-bit words in this order: instruction address bits 31:16, instruction address bits 15:0, the word 0x2024 (format 0x2 in bits 15:12, vector offset 9*4 in bits 11:0), next PC bits 31:16, next PC bits 15:0, status register. One word is consumed per cycle in which push_valid_o and push_ready_i are both high. push_data_o holds steady while push_ready_i is low.
- R9: push_done_o pulses for one cycle after the last word is accepted, and stall_o drops in that same cycle.
- R10: instr_end_i while stall_o is high raises no trace and does not disturb the frame being pushed.
- R11: Mode 2'b11 raises no trace. rsvd_mode_o goes high when that mode is sampled and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_start_i | input | 1 | Instruction begins; samples trace_mode_i |
| trace_mode_i | input | 2 | Trace mode field of the status register |
| instr_end_i | input | 1 | Instruction ends; flags below are valid |
| retired_i | input | 1 | Instruction completed execution |
| flow_break_i | input | 1 | PC left sequential order |
| irq_taken_i | input | 1 | Interrupt taken instead of the instruction |
| bad_opcode_i | input | 1 | Illegal, unimplemented or privileged opcode |
| instr_addr_i | input | 32 | Address of the ending instruction |
| next_pc_i | input | 32 | Address of the next instruction |
| status_i | input | 16 | Status register copy for the frame |
| trace_req_o | output | 1 | One-cycle trace exception request |
| stall_o | output | 1 | Blocks issue of the next instruction |
| push_valid_o | output | 1 | Frame word valid |
| push_data_o | output | 16 | Frame word |
| push_ready_i | input | 1 | Stack writer accepts the word |
| push_done_o | output | 1 | Frame push complete |
| rsvd_mode_o | output | 1 | Sticky: reserved mode was sampled |

## Verification
Instructions are run in every mode, with taken and not-taken flow changes, and with each of the three non-execution causes. This separates the step rule from the flow rule and shows that suppression overrides both. Changing the mode between start and end shows that the start-time sample is what counts. Frames are drained with ready held high, with ready throttled pseudo-randomly, and with ready held low while further instruction ends arrive. These cases expose errors in word order, hold behaviour, done timing and nested-trace masking. A reserved-mode instruction, followed by a reset, checks that the flag is sticky and that reset clears it.

// File: rtl/trace_pkg.sv
package trace_pkg;
  typedef enum logic [1:0] {
    TM_OFF  = 2'b00,
    TM_FLOW = 2'b01,
    TM_STEP = 2'b10,
    TM_RSVD = 2'b11
  } trace_mode_e;

  localparam logic [3:0] FRAME_FMT = 4'h2;
  localparam int unsigned TRACE_VEC = 9;
endpackage

// File: rtl/trace_mode_latch.sv
module trace_mode_latch
  import trace_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [1:0]  mode_i,
  output trace_mode_e mode_o,
  output logic        rsvd_seen_o
);
  trace_mode_e mode_q;
  logic        rsvd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= TM_OFF;
      rsvd_q <= 1'b0;
    end else if (start_i) begin
      mode_q <= trace_mode_e'(mode_i);
      if (trace_mode_e'(mode_i) == TM_RSVD) rsvd_q <= 1'b1;
    end
  end

  assign mode_o      = mode_q;
  assign rsvd_seen_o = rsvd_q;
endmodule

// File: rtl/trace_decide.sv
module trace_decide
  import trace_pkg::*;
(
  input  trace_mode_e mode_i,
  input  logic        retired_i,
  input  logic        flow_break_i,
  input  logic        irq_i,
  input  logic        bad_op_i,
  output logic        fire_o
);
  logic executed;

  assign executed = retired_i & ~irq_i & ~bad_op_i;

  always_comb begin
    unique case (mode_i)
      TM_STEP: fire_o = executed;
      TM_FLOW: fire_o = executed & flow_break_i;
      default: fire_o = 1'b0; // off and reserved
    endcase
  end
endmodule

// File: rtl/trace_frame_seq.sv
module trace_frame_seq
  import trace_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [WORD_W-1:0] sr_i,
  output logic              busy_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [WORD_W-1:0] data_o,
  output logic              done_o
);
  localparam int unsigned AW_WORDS = ADDR_W / WORD_W;
  localparam int unsigned N_WORDS  = 2 * AW_WORDS + 2;
  localparam int unsigned IDX_W    = $clog2(N_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);
  localparam logic [WORD_W-1:0] VEC_WORD = {FRAME_FMT, (WORD_W-4)'(TRACE_VEC * 4)};

  logic [WORD_W-1:0] frame_d [N_WORDS];
  logic [WORD_W-1:0] frame_q [N_WORDS];
  logic [IDX_W-1:0]  idx_q;
  logic              busy_q;
  logic              done_q;

  // address words high first, then vector word, PC words high first, SR last
  for (genvar i = 0; i < AW_WORDS; i++) begin : g_addr_words
    assign frame_d[i]              = addr_i[ADDR_W-1-i*WORD_W -: WORD_W];
    assign frame_d[AW_WORDS+1+i]   = pc_i[ADDR_W-1-i*WORD_W -: WORD_W];
  end
  assign frame_d[AW_WORDS]  = VEC_WORD;
  assign frame_d[N_WORDS-1] = sr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      idx_q  <= '0;
      for (int k = 0; k < N_WORDS; k++) frame_q[k] <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (load_i) begin
          for (int k = 0; k < N_WORDS; k++) frame_q[k] <= frame_d[k];
          busy_q <= 1'b1;
          idx_q  <= '0;
        end
      end else if (ready_i) begin
        if (idx_q == LAST_IDX) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          idx_q  <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign busy_o  = busy_q;
  assign valid_o = busy_q;
  assign data_o  = frame_q[idx_q];
  assign done_o  = done_q;
endmodule

// File: rtl/instr_trace_ctl.sv
module instr_trace_ctl
  import trace_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_start_i,
  input  logic [1:0]        trace_mode_i,
  input  logic              instr_end_i,
  input  logic              retired_i,
  input  logic              flow_break_i,
  input  logic              irq_taken_i,
  input  logic              bad_opcode_i,
  input  logic [ADDR_W-1:0] instr_addr_i,
  input  logic [ADDR_W-1:0] next_pc_i,
  input  logic [WORD_W-1:0] status_i,
  output logic              trace_req_o,
  output logic              stall_o,
  output logic              push_valid_o,
  output logic [WORD_W-1:0] push_data_o,
  input  logic              push_ready_i,
  output logic              push_done_o,
  output logic              rsvd_mode_o
);
  trace_mode_e mode_q;
  logic        fire;
  logic        busy;
  logic        accept;
  logic        req_q;

  trace_mode_latch i_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (instr_start_i),
    .mode_i     (trace_mode_i),
    .mode_o     (mode_q),
    .rsvd_seen_o(rsvd_mode_o)
  );

  trace_decide i_decide (
    .mode_i      (mode_q),
    .retired_i   (retired_i),
    .flow_break_i(flow_break_i),
    .irq_i       (irq_taken_i),
    .bad_op_i    (bad_opcode_i),
    .fire_o      (fire)
  );

  // own exception in flight masks further traces
  assign accept = instr_end_i & fire & ~busy;

  trace_frame_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .addr_i (instr_addr_i),
    .pc_i   (next_pc_i),
    .sr_i   (status_i),
    .busy_o (busy),
    .valid_o(push_valid_o),
    .ready_i(push_ready_i),
    .data_o (push_data_o),
    .done_o (push_done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= accept;
  end

  assign trace_req_o = req_q;
  assign stall_o     = busy;
endmodule

// File: rtl/instr_trace_ctl_chk.sv
module instr_trace_ctl_chk
  import trace_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              instr_end_i,
  input logic              retired_i,
  input logic              irq_taken_i,
  input logic              bad_opcode_i,
  input trace_mode_e       mode_q,
  input logic              trace_req_o,
  input logic              stall_o,
  input logic              push_valid_o,
  input logic [WORD_W-1:0] push_data_o,
  input logic              push_ready_i,
  input logic              push_done_o,
  input logic              rsvd_mode_o
);
  AST_OFF_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_end_i && !stall_o && (mode_q == TM_OFF || mode_q == TM_RSVD) |=> !trace_req_o); // R3

  AST_NOT_EXEC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_end_i && (!retired_i || irq_taken_i || bad_opcode_i) |=> !trace_req_o); // R6

  AST_REQ_STALLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trace_req_o |-> stall_o && push_valid_o); // R7

  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_valid_o && !push_ready_i |=> push_valid_o && $stable(push_data_o)); // R8

  AST_DONE_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_done_o |-> !stall_o && $past(stall_o)); // R9

  AST_NO_NESTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o && instr_end_i |=> !trace_req_o); // R10

  AST_RSVD_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_mode_o |=> rsvd_mode_o); // R11
endmodule

bind instr_trace_ctl instr_trace_ctl_chk #(.WORD_W(WORD_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .instr_end_i (instr_end_i),
  .retired_i   (retired_i),
  .irq_taken_i (irq_taken_i),
  .bad_opcode_i(bad_opcode_i),
  .mode_q      (mode_q),
  .trace_req_o (trace_req_o),
  .stall_o     (stall_o),
  .push_valid_o(push_valid_o),
  .push_data_o (push_data_o),
  .push_ready_i(push_ready_i),
  .push_done_o (push_done_o),
  .rsvd_mode_o (rsvd_mode_o)
);

// File: tb/test_instr_trace_ctl.sv
module test_instr_trace_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        iend = 1'b0;
  logic        ret = 1'b0, fb = 1'b0, irq = 1'b0, bad = 1'b0;
  logic [31:0] addr = '0, npc = '0;
  logic [15:0] sr = '0;
  logic        rdy = 1'b1;
  logic        trace_req, stall, pvalid, pdone, rsvd;
  logic [15:0] pdata;

  int n_checks = 0, n_fail = 0, n_req = 0, n_done = 0, cyc = 0;
  bit rnd_rdy = 0, hold_rdy_low = 0, finished = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [15:0] got_q[$];

  // reference model state
  int          m_mode = 0;
  bit          m_busy = 0, m_req = 0, m_done = 0, m_rsvd = 0;
  logic [15:0] m_q[$];

  always #5 clk = ~clk;

  instr_trace_ctl i_instr_trace_ctl (
    .clk_i(clk), .rst_ni(rst_n), .instr_start_i(start), .trace_mode_i(mode),
    .instr_end_i(iend), .retired_i(ret), .flow_break_i(fb), .irq_taken_i(irq),
    .bad_opcode_i(bad), .instr_addr_i(addr), .next_pc_i(npc), .status_i(sr),
    .trace_req_o(trace_req), .stall_o(stall), .push_valid_o(pvalid),
    .push_data_o(pdata), .push_ready_i(rdy), .push_done_o(pdone), .rsvd_mode_o(rsvd)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_busy = 0; m_req = 0; m_done = 0; m_rsvd = 0; m_q.delete();
    end else begin
      bit exec, f;
      m_req = 0; m_done = 0;
      if (m_busy) begin
        if (rdy) begin
          void'(m_q.pop_front());
          if (m_q.size() == 0) begin m_busy = 0; m_done = 1; end
        end
      end else if (iend) begin
        exec = ret && !irq && !bad;
        f = exec && (m_mode == 2 || (m_mode == 1 && fb));
        if (f) begin
          m_q = '{addr[31:16], addr[15:0], 16'h2024, npc[31:16], npc[15:0], sr};
          m_busy = 1; m_req = 1;
        end
      end
      if (start) begin
        if (mode == 2'b11) m_rsvd = 1;
        m_mode = mode;
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n && !finished) begin
      chk("R2 R3 R4 R5 R6 R10 R11 trace_req", trace_req, m_req);
      chk("R7 stall", stall, m_busy);
      chk("R8 valid", pvalid, m_busy);
      if (m_busy) chk("R8 data", pdata, m_q[0]);
      chk("R9 done", pdone, m_done);
      chk("R11 rsvd", rsvd, m_rsvd);
      if (trace_req) n_req++;
      if (pdone) n_done++;
    end
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog act=%0d exp=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  task automatic tick();
    @(negedge clk);
    #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (hold_rdy_low) rdy = 1'b0;
    else if (rnd_rdy) rdy = lfsr[0];
    else rdy = 1'b1;
    if (pvalid && rdy) got_q.push_back(pdata);
  endtask

  task automatic drain();
    for (int i = 0; i < 200 && stall; i++) tick();
    tick();
  endtask

  task automatic run_instr(input logic [1:0] m0, input logic [1:0] m1,
                           input bit r, input bit b, input bit q, input bit o,
                           input logic [31:0] a, input logic [31:0] p,
                           input logic [15:0] s, input string tag);
    bit exp;
    exp = r && !q && !o && (m0 == 2'b10 || (m0 == 2'b01 && b));
    got_q.delete();
    tick(); start = 1; mode = m0;
    tick(); start = 0; mode = m1;
    tick(); iend = 1; ret = r; fb = b; irq = q; bad = o; addr = a; npc = p; sr = s;
    tick(); iend = 0; ret = 0; fb = 0; irq = 0; bad = 0;
    chk({tag, " R7 req pulse"}, trace_req, exp);
    chk({tag, " R7 stall rise"}, stall, exp);
    drain();
    if (exp) begin
      chk({tag, " R8 word count"}, got_q.size(), 6);
      if (got_q.size() == 6) begin
        chk({tag, " R8 w0"}, got_q[0], a[31:16]);
        chk({tag, " R8 w1"}, got_q[1], a[15:0]);
        chk({tag, " R8 w2"}, got_q[2], 16'h2024);
        chk({tag, " R8 w3"}, got_q[3], p[31:16]);
        chk({tag, " R8 w4"}, got_q[4], p[15:0]);
        chk({tag, " R8 w5"}, got_q[5], s);
      end
    end
  endtask

  initial begin
    int base, dbase;
    repeat (3) @(negedge clk);
    chk("R1 trace_req", trace_req, 0);
    chk("R1 stall", stall, 0);
    chk("R1 valid", pvalid, 0);
    chk("R1 done", pdone, 0);
    chk("R1 rsvd", rsvd, 0);
    rst_n = 1;
    tick();

    base = n_req;
    run_instr(2'b00, 2'b00, 1, 1, 0, 0, 32'h1000, 32'h2000, 16'h2700, "R3 off");
    chk("R3 no trace", n_req - base, 0);

    base = n_req;
    run_instr(2'b01, 2'b01, 1, 1, 0, 0, 32'h0012_3456, 32'h0000_8000, 16'h6700, "R4 taken");
    chk("R4 taken traces", n_req - base, 1);
    base = n_req;
    run_instr(2'b01, 2'b01, 1, 0, 0, 0, 32'h0012_3458, 32'h0012_345A, 16'h6700, "R4 not taken");
    chk("R4 not taken quiet", n_req - base, 0);

    base = n_req; dbase = n_done;
    run_instr(2'b10, 2'b10, 1, 0, 0, 0, 32'hDEAD_BEEF, 32'hCAFE_F00D, 16'hA5A5, "R5 step");
    chk("R5 step traces", n_req - base, 1);
    chk("R9 one done", n_done - dbase, 1);

    base = n_req;
    run_instr(2'b10, 2'b10, 1, 0, 1, 0, 32'h100, 32'h104, 16'h8000, "R6 irq");
    run_instr(2'b10, 2'b10, 1, 0, 0, 1, 32'h200, 32'h204, 16'h8000, "R6 bad");
    run_instr(2'b01, 2'b01, 0, 1, 0, 0, 32'h300, 32'h400, 16'h8000, "R6 unretired");
    chk("R6 suppressed", n_req - base, 0);

    base = n_req;
    run_instr(2'b10, 2'b00, 1, 0, 0, 0, 32'h0A00_0010, 32'h0A00_0012, 16'h2000, "R2 step->off");
    chk("R2 start mode kept", n_req - base, 1);
    base = n_req;
    run_instr(2'b00, 2'b10, 1, 1, 0, 0, 32'h0A00_0020, 32'h0A00_0022, 16'h2000, "R2 off->step");
    chk("R2 late mode ignored", n_req - base, 0);

    rnd_rdy = 1;
    for (int i = 0; i < 20; i++)
      run_instr(2'(1 + (i % 2)), 2'(i % 4), 1, i[2], 0, 0,
                32'h4000_0000 + 32'(i * 6), 32'h5000_0000 + 32'(i * 70),
                16'(16'h1111 * i), "R8 throttled");
    rnd_rdy = 0;

    // R10: instruction ends while the frame is held back
    base = n_req;
    tick(); start = 1; mode = 2'b10;
    tick(); start = 0;
    tick(); iend = 1; ret = 1; addr = 32'h7777_0000; npc = 32'h7777_0002; sr = 16'h0707;
    hold_rdy_low = 1;
    tick(); iend = 0; ret = 0;
    tick(); iend = 1; ret = 1; fb = 1; addr = 32'h9999_9999; npc = 32'h1; sr = 16'hFFFF;
    tick(); iend = 0; ret = 0; fb = 0;
    chk("R10 stall held", stall, 1);
    chk("R10 first word intact", pdata, 16'h7777);
    hold_rdy_low = 0;
    got_q.delete();
    drain();
    chk("R10 single trace", n_req - base, 1);
    chk("R10 frame size", got_q.size(), 6);
    if (got_q.size() == 6) chk("R10 sr word", got_q[5], 16'h0707);

    base = n_req;
    run_instr(2'b11, 2'b11, 1, 1, 0, 0, 32'h123, 32'h456, 16'h0, "R11 reserved");
    chk("R11 no trace", n_req - base, 0);
    chk("R11 flag set", rsvd, 1);
    run_instr(2'b00, 2'b00, 1, 0, 0, 0, 32'h0, 32'h2, 16'h0, "R11 later");
    chk("R11 flag sticky", rsvd, 1);
    rst_n = 0;
    tick();
    chk("R11 flag cleared by reset", rsvd, 0);
    chk("R1 stall after reset", stall, 0);
    rst_n = 1;
    repeat (3) tick();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule